// File: doc/BRIEF.md
# Masked Packed FP16 Lane Controller

This block wraps a row of replicated half-precision element units and handles everything around them for one vector operation of 128, 256 or 512 bits. Each cycle that `validIn` is high it takes two source vectors, the previous destination value, a per-lane mask and a handful of control bits. It then selects the second operand of every lane, either the lane's own element or a copy of element 0. It decides which lanes compute, which keep their old value and which are forced to zero, and it clears everything beyond the active length. It also picks one rounding mode for the whole operation.

The element units apply a scale step to each lane. Their status bits are ORed only over lanes that actually computed. All results are registered once and appear with `validOut` one cycle after the request. The element unit here is a stand-in integer-exponent scaler so that the wrapper can be exercised end to end. The wrapper logic does not depend on what the lane computes.

Top module: `vscaleLaneCtrl`

## Requirements
- R1: The length code `vlSel` selects the number of active 16-bit lanes: 2'b00 gives 8 lanes (128 bits), 2'b01 gives 16 lanes (256 bits), 2'b10 and 2'b11 give 32 lanes (512 bits).
- R2: An active lane i takes the element unit result when `noMask` is high or `laneMask[i]` is high; `laneMask` bits of lanes beyond the active length have no effect.
- R3: When `memSrc` and `bcastBit` are both high, every lane uses bits [15:0] of `srcB` as its second operand; in every other case lane i uses `srcB[16*i+15:16*i]`.
- R4: An active lane that does not compute is written with 16'h0000 when `zeroMode` is high, and with the matching slice of `destOld` otherwise.
- R5: Destination bits from 16 times the active lane count up to bit 511 are zero, whatever `destOld`, the mask or the sources hold.
- R6: `rmOut` equals `embRc` when the length is 512 bits, `bcastBit` is high and `memSrc` is low; in every other case it equals `csrRc`.
- R7: `flagsOut` (bit 0 invalid, bit 1 overflow, bit 2 underflow) is the OR of the status bits of computing lanes only; lanes that are inactive or merged/zeroed contribute nothing.
- R8: The element unit treats operand b as a 16-bit two's complement integer k. If a has exponent field 31, the result is a, with the invalid flag when its fraction is nonzero. If a has exponent field 0, the result is a. Otherwise let e = exponent + k: e >= 31 gives a signed infinity with overflow, e <= 0 gives a signed zero with underflow, and any other e replaces the exponent field with e.
- R9: `validOut`, `destOut`, `rmOut` and `flagsOut` are registered. A request with `validIn` high appears exactly one cycle later. Cycles with `validIn` low leave the outputs unchanged and drop `validOut`. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Request strobe |
| vlSel | input | 2 | Vector length code |
| srcA | input | 512 | First source, 32 FP16 lanes |
| srcB | input | 512 | Second source (scale operands) |
| destOld | input | 512 | Previous destination contents for merging |
| laneMask | input | 32 | Per-lane write mask |
| noMask | input | 1 | Ignore mask, compute every active lane |
| zeroMode | input | 1 | Non-computing lanes become zero instead of merging |
| bcastBit | input | 1 | Broadcast / embedded-rounding control bit |
| memSrc | input | 1 | Second source comes from memory |
| embRc | input | 2 | Rounding mode carried in the request |
| csrRc | input | 2 | Rounding mode from the control register |
| validOut | output | 1 | Result strobe, one cycle after validIn |
| destOut | output | 512 | Assembled destination |
| rmOut | output | 2 | Rounding mode chosen for all lanes |
| flagsOut | output | 3 | OR of computing-lane status bits |

## Verification
A wrong lane-enable vector shows up in the same result beat as a wrong 16-bit slice of `destOut`. That slice holds a computed value where an old or zero value belonged, or the reverse. The same error often leaks into `flagsOut` when a masked lane holds an operand that would overflow. A broken length decode appears as nonzero bits in the upper portion of a short result. A broken operand select shows as lanes computed against their own element instead of element 0. Every such error is visible on the first result that follows the faulty request, so the scoreboard compares each beat in full rather than only the last one.

// File: rtl/vscalePkg.sv
package vscalePkg;
  localparam int LANE_W    = 16;
  localparam int VEC_W     = 512;
  localparam int MAX_LANES = VEC_W / LANE_W;
  localparam int FLAG_W    = 3;
  localparam int RM_W      = 2;
  localparam int CNT_W     = $clog2(MAX_LANES) + 1;

  // status bit positions inside a lane flag vector
  localparam int FLG_INVALID   = 0;
  localparam int FLG_OVERFLOW  = 1;
  localparam int FLG_UNDERFLOW = 2;

  typedef struct packed {
    logic [MAX_LANES-1:0] laneActive;   // lane lies inside the active length
    logic [MAX_LANES-1:0] laneCompute;  // lane takes the element result
    logic                 zeroFill;     // non-computing active lanes go to zero
    logic                 bcastSel;     // every lane uses element 0 of srcB
    logic [RM_W-1:0]      rmSel;        // rounding mode for the operation
    logic                 load;         // capture results this cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/fp16ScaleLane.sv
module fp16ScaleLane
  import vscalePkg::*;
(
  input  logic [LANE_W-1:0] opA,
  input  logic [LANE_W-1:0] opB,
  output logic [LANE_W-1:0] res,
  output logic [FLAG_W-1:0] flags
);
  localparam int EXP_W  = 5;
  localparam int FRAC_W = 10;
  localparam int SUM_W  = LANE_W + 2;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  logic [EXP_W-1:0]        expA;
  logic [FRAC_W-1:0]       fracA;
  logic                    signA;
  logic signed [SUM_W-1:0] expSum;

  assign signA = opA[LANE_W-1];
  assign expA  = opA[FRAC_W +: EXP_W];
  assign fracA = opA[FRAC_W-1:0];
  assign expSum = $signed({{(SUM_W-EXP_W){1'b0}}, expA}) +
                  $signed({{(SUM_W-LANE_W){opB[LANE_W-1]}}, opB});

  always_comb begin
    res   = opA;
    flags = '0;
    if (expA == EXP_MAX) begin
      flags[FLG_INVALID] = |fracA;
    end else if (expA == '0) begin
      res = opA;
    end else if (expSum >= $signed(SUM_W'(EXP_MAX))) begin
      res = {signA, EXP_MAX, {FRAC_W{1'b0}}};
      flags[FLG_OVERFLOW] = 1'b1;
    end else if (expSum <= $signed(SUM_W'(0))) begin
      res = {signA, {(LANE_W-1){1'b0}}};
      flags[FLG_UNDERFLOW] = 1'b1;
    end else begin
      res = {signA, expSum[EXP_W-1:0], fracA};
    end
  end
endmodule

// File: rtl/laneCtrlUnit.sv
module laneCtrlUnit
  import vscalePkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 validIn,
  input  logic [1:0]           vlSel,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic                 noMask,
  input  logic                 zeroMode,
  input  logic                 bcastBit,
  input  logic                 memSrc,
  input  logic [RM_W-1:0]      embRc,
  input  logic [RM_W-1:0]      csrRc,
  output ctrlStrobes_t         strobes,
  output logic                 validOut
);
  localparam int LANES_SHORT = 128 / LANE_W;
  localparam int LANES_MID   = 256 / LANE_W;
  localparam int LANES_FULL  = VEC_W / LANE_W;

  logic [CNT_W-1:0]     activeCnt;
  logic [MAX_LANES-1:0] activeVec;
  logic                 fullWidth;

  always_comb begin
    unique case (vlSel)
      2'b00:   activeCnt = CNT_W'(LANES_SHORT);
      2'b01:   activeCnt = CNT_W'(LANES_MID);
      default: activeCnt = CNT_W'(LANES_FULL);
    endcase
  end

  assign fullWidth = (activeCnt == CNT_W'(LANES_FULL));

  for (genvar gi = 0; gi < MAX_LANES; gi++) begin : g_active
    assign activeVec[gi] = (CNT_W'(gi) < activeCnt);
  end

  always_comb begin
    strobes.laneActive  = activeVec;
    strobes.laneCompute = activeVec & (noMask ? {MAX_LANES{1'b1}} : laneMask);
    strobes.zeroFill    = zeroMode;
    strobes.bcastSel    = memSrc & bcastBit;
    strobes.rmSel       = (fullWidth && bcastBit && !memSrc) ? embRc : csrRc;
    strobes.load        = validIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
  assert_short_active_R1: assert property (@(posedge clk) disable iff (!rstN)
    (vlSel == 2'b00) |-> ($countones(strobes.laneActive) == LANES_SHORT));
endmodule

// File: rtl/laneDatapath.sv
module laneDatapath
  import vscalePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] destOld,
  output logic [VEC_W-1:0] destQ,
  output logic [RM_W-1:0]  rmQ,
  output logic [FLAG_W-1:0] flagsQ
);
  localparam int LANES = MAX_LANES;
  localparam int SHORT_TOP = 128;
  localparam int MID_TOP   = 256;

  logic [LANE_W-1:0] laneRes   [LANES];
  logic [FLAG_W-1:0] laneFlags [LANES];
  logic [VEC_W-1:0]  destNext;
  logic [FLAG_W-1:0] flagsNext;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [LANE_W-1:0] opB;
    assign opB = strobes.bcastSel ? srcB[LANE_W-1:0] : srcB[gi*LANE_W +: LANE_W];

    fp16ScaleLane u_lane (
      .opA  (srcA[gi*LANE_W +: LANE_W]),
      .opB  (opB),
      .res  (laneRes[gi]),
      .flags(laneFlags[gi])
    );

    assign destNext[gi*LANE_W +: LANE_W] =
        !strobes.laneActive[gi]  ? '0 :
         strobes.laneCompute[gi] ? laneRes[gi] :
         strobes.zeroFill        ? '0 :
                                   destOld[gi*LANE_W +: LANE_W];
  end

  always_comb begin
    flagsNext = '0;
    for (int i = 0; i < LANES; i++) begin
      if (strobes.laneCompute[i]) flagsNext = flagsNext | laneFlags[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destQ  <= '0;
      rmQ    <= '0;
      flagsQ <= '0;
    end else if (strobes.load) begin
      destQ  <= destNext;
      rmQ    <= strobes.rmSel;
      flagsQ <= flagsNext;
    end
  end

  assert_upper_short_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.laneActive[SHORT_TOP/LANE_W]) |=> (destQ[VEC_W-1:SHORT_TOP] == '0));
  assert_upper_mid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.laneActive[MID_TOP/LANE_W]) |=> (destQ[VEC_W-1:MID_TOP] == '0));
  assert_no_compute_no_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.laneCompute == '0) |=> (flagsQ == '0));
  assert_zero_lane0_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.zeroFill && !strobes.laneCompute[0]) |=> (destQ[LANE_W-1:0] == '0));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(destQ) && $stable(flagsQ) && $stable(rmQ)));
endmodule

// File: rtl/vscaleLaneCtrl.sv
module vscaleLaneCtrl
  import vscalePkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 validIn,
  input  logic [1:0]           vlSel,
  input  logic [VEC_W-1:0]     srcA,
  input  logic [VEC_W-1:0]     srcB,
  input  logic [VEC_W-1:0]     destOld,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic                 noMask,
  input  logic                 zeroMode,
  input  logic                 bcastBit,
  input  logic                 memSrc,
  input  logic [RM_W-1:0]      embRc,
  input  logic [RM_W-1:0]      csrRc,
  output logic                 validOut,
  output logic [VEC_W-1:0]     destOut,
  output logic [RM_W-1:0]      rmOut,
  output logic [FLAG_W-1:0]    flagsOut
);
  ctrlStrobes_t strobes;

  laneCtrlUnit u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .vlSel   (vlSel),
    .laneMask(laneMask),
    .noMask  (noMask),
    .zeroMode(zeroMode),
    .bcastBit(bcastBit),
    .memSrc  (memSrc),
    .embRc   (embRc),
    .csrRc   (csrRc),
    .strobes (strobes),
    .validOut(validOut)
  );

  laneDatapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .srcA   (srcA),
    .srcB   (srcB),
    .destOld(destOld),
    .destQ  (destOut),
    .rmQ    (rmOut),
    .flagsQ (flagsOut)
  );

  assert_embedded_rm_R6: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && vlSel[1] && bcastBit && !memSrc) |=> (rmOut == $past(embRc)));
  assert_csr_rm_R6: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && (!vlSel[1] || !bcastBit || memSrc)) |=> (rmOut == $past(csrRc)));
endmodule

// File: tb/sim_vscaleLaneCtrl.sv
module sim_vscaleLaneCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic [1:0] vlSel = '0;
  logic [511:0] srcA = '0, srcB = '0, destOld = '0;
  logic [31:0] laneMask = '0;
  logic noMask = 1'b0, zeroMode = 1'b0, bcastBit = 1'b0, memSrc = 1'b0;
  logic [1:0] embRc = '0, csrRc = '0;
  logic validOut;
  logic [511:0] destOut;
  logic [1:0] rmOut;
  logic [2:0] flagsOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [511:0] d;
    logic [1:0]   rm;
    logic [2:0]   fl;
    string        tag;
  } expItem_t;
  expItem_t sb[$];

  always #10 clk = ~clk;

  vscaleLaneCtrl u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .vlSel(vlSel),
    .srcA(srcA), .srcB(srcB), .destOld(destOld), .laneMask(laneMask),
    .noMask(noMask), .zeroMode(zeroMode), .bcastBit(bcastBit), .memSrc(memSrc),
    .embRc(embRc), .csrRc(csrRc), .validOut(validOut), .destOut(destOut),
    .rmOut(rmOut), .flagsOut(flagsOut)
  );

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent model of one element (R8)
  function automatic logic [18:0] laneModel(input logic [15:0] a, input logic [15:0] b);
    int e, k, s;
    logic [15:0] r;
    logic [2:0] f;
    e = int'(a[14:10]);
    k = int'($signed(b));
    s = e + k;
    f = 3'b000;
    r = a;
    if (e == 31) f[0] = (a[9:0] != 0);
    else if (e == 0) r = a;
    else if (s >= 31) begin r = {a[15], 5'h1f, 10'h0}; f[1] = 1'b1; end
    else if (s <= 0) begin r = {a[15], 15'h0}; f[2] = 1'b1; end
    else r = {a[15], 5'(s), a[9:0]};
    return {f, r};
  endfunction

  task automatic sendOp(input string tag, input logic [1:0] vl, input logic [511:0] a,
                        input logic [511:0] b, input logic [511:0] old, input logic [31:0] m,
                        input logic nm, input logic zm, input logic bc, input logic mem,
                        input logic [1:0] emb, input logic [1:0] csr);
    expItem_t it;
    int nl;
    logic [18:0] lr;
    logic [15:0] bb;
    nl = (vl == 2'b00) ? 8 : (vl == 2'b01) ? 16 : 32;
    it.d = '0; it.fl = '0; it.tag = tag;
    for (int i = 0; i < 32; i++) begin
      bb = (bc && mem) ? b[15:0] : b[i*16 +: 16];
      lr = laneModel(a[i*16 +: 16], bb);
      if (i >= nl)             it.d[i*16 +: 16] = '0;
      else if (nm || m[i])     begin it.d[i*16 +: 16] = lr[15:0]; it.fl |= lr[18:16]; end
      else if (zm)             it.d[i*16 +: 16] = '0;
      else                     it.d[i*16 +: 16] = old[i*16 +: 16];
    end
    it.rm = (vl[1] && bc && !mem) ? emb : csr;
    @(negedge clk);
    validIn = 1'b1; vlSel = vl; srcA = a; srcB = b; destOld = old; laneMask = m;
    noMask = nm; zeroMode = zm; bcastBit = bc; memSrc = mem; embRc = emb; csrRc = csr;
    sb.push_back(it);
  endtask

  // monitor / scoreboard
  always begin
    @(negedge clk);
    #1;
    if (validOut && rstN) begin
      if (sb.size() == 0) begin
        check("R9 unexpected validOut", 512'd1, 512'd0);
      end else begin
        expItem_t it;
        it = sb.pop_front();
        check({it.tag, " dest"}, destOut, it.d);
        check("R6 rounding", 512'(rmOut), 512'(it.rm));
        check("R7 flags", 512'(flagsOut), 512'(it.fl));
      end
    end
  end

  function automatic logic [511:0] fillA(input int seed);
    logic [511:0] v;
    for (int i = 0; i < 32; i++) v[i*16 +: 16] = {1'b0, 5'(10 + (i % 8)), 10'(i * 37 + seed)};
    return v;
  endfunction

  function automatic logic [511:0] fillB(input int seed);
    logic [511:0] v;
    for (int i = 0; i < 32; i++) v[i*16 +: 16] = 16'((i + seed) % 5 - 2);
    return v;
  endfunction

  initial begin
    #(20 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [511:0] a, b, old, held;
    old = {16{32'hA5A5_5A5A}};
    repeat (3) @(negedge clk);
    // reset state
    check("R9 reset validOut", 512'(validOut), 512'd0);
    check("R9 reset dest", destOut, 512'd0);
    rstN = 1'b1;

    // R8/R6: full width, no mask, register source with bcast bit -> embedded rounding
    sendOp("R8", 2'b10, fillA(3), fillB(0), old, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 2'd1);
    // R3: memory broadcast, 128 bits, merge
    b = fillB(1); b[15:0] = 16'h0003;
    sendOp("R3", 2'b00, fillA(7), b, old, 32'hFFFF_FFA5, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'd0);
    // R4: zeroing at 256 bits
    sendOp("R4", 2'b01, fillA(11), fillB(2), old, 32'h0F0F_0F0F, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd2);
    // R5: 256 bits, bcast bit with register source (no broadcast, csr rounding)
    sendOp("R5", 2'b01, fillA(5), fillB(3), ~old, 32'hFFFF_3C3C, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 2'd2);
    // R2: code 3 is full width, merge with sparse mask
    sendOp("R2", 2'b11, fillA(9), fillB(4), old, 32'h8000_0001, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd3);
    // R7: odd lanes would overflow but are masked; even lanes underflow
    a = '0; b = '0;
    for (int i = 0; i < 32; i++) begin
      if (i % 2) begin a[i*16 +: 16] = 16'h7800; b[i*16 +: 16] = 16'd5; end
      else       begin a[i*16 +: 16] = 16'h8800; b[i*16 +: 16] = 16'hFFFB; end
    end
    sendOp("R7", 2'b10, a, b, old, 32'h5555_5555, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1);
    // R1: 128 bits with a NaN lane and invalid flag, no mask
    a = fillA(2); a[3*16 +: 16] = 16'h7E01; a[20*16 +: 16] = 16'h7E01;
    sendOp("R1", 2'b00, a, fillB(0), old, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0);
    @(negedge clk);
    validIn = 1'b0;
    srcA = '1; destOld = '1; laneMask = '1;
    repeat (2) @(negedge clk);
    #2;
    held = destOut;
    repeat (3) @(negedge clk);
    #2;
    check("R9 idle validOut", 512'(validOut), 512'd0);
    check("R9 idle hold", destOut, held);
    check("R9 queue drained", 512'(sb.size()), 512'd0);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule